// File: doc/BRIEF.md
# Interrupt Redirection Table

This block turns a set of external interrupt lines into interrupt messages. Every entry of the table holds 64 bits of routing data: a vector, a delivery mode, a destination mode, a polarity flag, a trigger mode, a mask flag and an 8-bit destination. Each entry keeps a pending flag. An edge-mode entry latches a rising edge on its line. A level-mode entry follows its line. The lowest-numbered entry that is pending and unmasked is placed in an output message register, and that register is handed off over a valid/ready interface.

Software reaches the table through two 32-bit locations. The first is a select register. The second is a data window whose meaning depends on the select value. Each 64-bit entry is split over two neighbouring select values, so either half can be rewritten without touching the other. The block has an identification word and a read-only capability word. Input line 0 is steered onto entry 2, which also receives line 2. No line drives entry 0.

Top module: `irq_route_table`

## Requirements
- R1: A write to bus offset 0x00 loads the 8-bit select register from wdata[7:0]. A read at offset 0x00 returns it zero-extended to 32 bits. Every read returns its data on bus_rdata after the next rising clock edge.
- R2: At select value 0, the window holds an identification byte in bits 31:24. Only those bits can be written, and bits 23:0 read 0.
- R3: At select value 1, the window reads 0x00170011, which is 0x11 with the highest entry number (NUM_PINS-1) in bits 23:16, and writes to it are ignored. Select 2 reads 0 and ignores writes. Select values at or beyond 0x10+2*NUM_PINS, and bus offsets other than 0x00 and 0x10, read 0 and ignore writes.
- R4: Entry n is reached at select 0x10+2n (bits 31:0) and 0x11+2n (bits 63:32) through window offset 0x10. A write to one half leaves the other half unchanged.
- R5: The entry fields are as follows: vector in bits 7:0, delivery mode in 10:8, destination mode in 11, polarity in 13, trigger mode in 15 (1 = level), mask in 16 and destination in 63:56. A message carries the fields of its entry as they stand when the message is loaded.
- R6: After reset, every entry reads 0x0000000000010000 (mask only). The select register, the identification byte and all pending flags are 0, and msg_valid is low.
- R7: On an edge-mode entry, a 0-to-1 change of its line sets the pending flag. The message is loaded on the edge after that, and loading it clears the flag. A line that stays high yields exactly one message.
- R8: On a level-mode entry, the pending flag follows the line. Such an entry yields one message per high period and is re-armed only after its line has been seen low.
- R9: A masked entry sends no message, and its pending edge is kept. Clearing the mask then sends the message.
- R10: When several entries are eligible, the lowest-numbered entry is sent first.
- R11: While msg_valid is high and msg_ready is low, msg_valid stays high and the message fields hold. A new message can be loaded on the same edge that completes a transfer.
- R12: Input line 0 raises entry 2. Entry 0 is never raised by any line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_line | input | NUM_PINS | External interrupt lines |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset: 0x00 select, 0x10 window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_valid | output | 1 | Message present |
| msg_dest | output | 8 | Destination |
| msg_dest_mode | output | 1 | Destination mode |
| msg_deliv | output | 3 | Delivery mode |
| msg_vector | output | 8 | Vector |
| msg_polarity | output | 1 | Polarity flag |
| msg_trigger | output | 1 | Trigger mode, 1 = level |

## Verification
Read data is due one rising edge after the read strobe. A message is due two rising edges after the input edge or level that causes it: one edge sets the pending flag and the next loads the message register. The bench drives inputs at falling edges. It samples at the falling edge that follows the counted rising edges, so the no-message checks on held lines, masked entries and entry 0 look in the window where a wrong message would already have to show. Ordering and stall behaviour are checked by holding msg_ready low across several cycles and then accepting one message per handshake.

// File: rtl/irt_pkg.sv
package irt_pkg;
  localparam int ENTRY_W   = 64;
  localparam int VEC_LSB   = 0;
  localparam int DLV_LSB   = 8;
  localparam int DMODE_BIT = 11;
  localparam int POL_BIT   = 13;
  localparam int TRIG_BIT  = 15;
  localparam int MASK_BIT  = 16;
  localparam int DEST_LSB  = 56;
  localparam logic [ENTRY_W-1:0] ENTRY_RESET = 64'h0000_0000_0001_0000;

  typedef struct packed {
    logic [7:0] dest;
    logic       dest_mode;
    logic [2:0] deliv;
    logic [7:0] vector;
    logic       polarity;
    logic       trigger;
  } irt_msg_t;

  function automatic irt_msg_t to_msg(input logic [ENTRY_W-1:0] e);
    irt_msg_t m;
    m.dest      = e[DEST_LSB +: 8];
    m.dest_mode = e[DMODE_BIT];
    m.deliv     = e[DLV_LSB +: 3];
    m.vector    = e[VEC_LSB +: 8];
    m.polarity  = e[POL_BIT];
    m.trigger   = e[TRIG_BIT];
    return m;
  endfunction
endpackage

// File: rtl/irt_regs.sv
module irt_regs
  import irt_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 8,
  parameter int SEL_OFS  = 8'h00,
  parameter int WIN_OFS  = 8'h10,
  parameter int TBL_BASE = 8'h10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [IDX_W-1:0]    sel_idx,
  output logic [ENTRY_W-1:0]  entries [NUM_PINS]
);
  localparam logic [DATA_W-1:0] CAP_WORD = DATA_W'(32'h11) | (DATA_W'(NUM_PINS - 1) << 16);

  logic             sel_wr, win_wr;
  logic [7:0]       id_q;
  logic [DATA_W-1:0] rd_val;

  assign sel_wr = bus_wr && (bus_addr == ADDR_W'(SEL_OFS));
  assign win_wr = bus_wr && (bus_addr == ADDR_W'(WIN_OFS));

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_idx <= '0;
      id_q    <= '0;
    end else begin
      if (sel_wr) sel_idx <= bus_wdata[IDX_W-1:0];
      if (win_wr && sel_idx == '0) id_q <= bus_wdata[31:24];
    end
  end

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_entry
    localparam logic [IDX_W-1:0] LO_IDX = IDX_W'(TBL_BASE + 2 * n);
    localparam logic [IDX_W-1:0] HI_IDX = IDX_W'(TBL_BASE + 2 * n + 1);
    always_ff @(posedge clk) begin
      if (rst) begin
        entries[n] <= ENTRY_RESET;
      end else if (win_wr && sel_idx == LO_IDX) begin
        entries[n][31:0] <= bus_wdata;
      end else if (win_wr && sel_idx == HI_IDX) begin
        entries[n][63:32] <= bus_wdata;
      end
    end
  end

  always_comb begin
    rd_val = '0;
    if (bus_addr == ADDR_W'(SEL_OFS)) begin
      rd_val = DATA_W'(sel_idx);
    end else if (bus_addr == ADDR_W'(WIN_OFS)) begin
      if (sel_idx == IDX_W'(0)) rd_val = {id_q, 24'h0};
      else if (sel_idx == IDX_W'(1)) rd_val = CAP_WORD;
      for (int n = 0; n < NUM_PINS; n++) begin
        if (sel_idx == IDX_W'(TBL_BASE + 2 * n))     rd_val = entries[n][31:0];
        if (sel_idx == IDX_W'(TBL_BASE + 2 * n + 1)) rd_val = entries[n][63:32];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end
endmodule

// File: rtl/irt_pend.sv
module irt_pend #(
  parameter int NUM_PINS  = 24,
  parameter int REMAP_SRC = 0,
  parameter int REMAP_DST = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] irq_line,
  input  logic [NUM_PINS-1:0] trig_lvl,
  input  logic [NUM_PINS-1:0] take,
  output logic [NUM_PINS-1:0] pend,
  output logic [NUM_PINS-1:0] sent
);
  logic [NUM_PINS-1:0] route, prev_q, rise;

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_route
    if (n == REMAP_DST) begin : g_dst
      assign route[n] = irq_line[n] | irq_line[REMAP_SRC];
    end else if (n == REMAP_SRC) begin : g_src
      assign route[n] = 1'b0;
    end else begin : g_same
      assign route[n] = irq_line[n];
    end
  end

  assign rise = route & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      pend   <= '0;
      sent   <= '0;
    end else begin
      prev_q <= route;
      for (int n = 0; n < NUM_PINS; n++) begin
        if (trig_lvl[n]) begin
          pend[n] <= route[n];
          sent[n] <= take[n] | (sent[n] & route[n]);
        end else begin
          pend[n] <= rise[n] | (pend[n] & ~take[n]);
          sent[n] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/irt_disp.sv
module irt_disp
  import irt_pkg::*;
#(
  parameter int NUM_PINS = 24,
  localparam int PIN_W   = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] elig,
  input  logic [ENTRY_W-1:0]  entries [NUM_PINS],
  input  logic                msg_ready,
  output logic                msg_valid,
  output irt_msg_t            msg,
  output logic                load_en,
  output logic [PIN_W-1:0]    load_pin,
  output logic [NUM_PINS-1:0] take
);
  logic any;

  always_comb begin
    any      = 1'b0;
    load_pin = '0;
    for (int n = NUM_PINS - 1; n >= 0; n--) begin
      if (elig[n]) begin
        any      = 1'b1;
        load_pin = PIN_W'(n);
      end
    end
  end

  assign load_en = any && (!msg_valid || msg_ready);

  always_comb begin
    take = '0;
    if (load_en) take[load_pin] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid <= 1'b0;
      msg       <= '0;
    end else if (load_en) begin
      msg_valid <= 1'b1;
      msg       <= to_msg(entries[load_pin]);
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_route_table.sv
module irq_route_table
  import irt_pkg::*;
#(
  parameter int NUM_PINS  = 24,
  parameter int REMAP_SRC = 0,
  parameter int REMAP_DST = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] irq_line,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [7:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic                msg_ready,
  output logic                msg_valid,
  output logic [7:0]          msg_dest,
  output logic                msg_dest_mode,
  output logic [2:0]          msg_deliv,
  output logic [7:0]          msg_vector,
  output logic                msg_polarity,
  output logic                msg_trigger
);
  localparam int PIN_W = $clog2(NUM_PINS);

  logic [ENTRY_W-1:0]  entries [NUM_PINS];
  logic [7:0]          sel_idx;
  logic [NUM_PINS-1:0] mask_vec, trig_vec, pend_vec, sent_vec, elig, take;
  logic                load_en;
  logic [PIN_W-1:0]    load_pin;
  irt_msg_t            msg;

  irt_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sel_idx(sel_idx), .entries(entries)
  );

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_ctl
    assign mask_vec[n] = entries[n][MASK_BIT];
    assign trig_vec[n] = entries[n][TRIG_BIT];
  end

  irt_pend #(.NUM_PINS(NUM_PINS), .REMAP_SRC(REMAP_SRC), .REMAP_DST(REMAP_DST)) u_pend (
    .clk(clk), .rst(rst), .irq_line(irq_line), .trig_lvl(trig_vec),
    .take(take), .pend(pend_vec), .sent(sent_vec)
  );

  assign elig = pend_vec & ~mask_vec & ~sent_vec;

  irt_disp #(.NUM_PINS(NUM_PINS)) u_disp (
    .clk(clk), .rst(rst), .elig(elig), .entries(entries),
    .msg_ready(msg_ready), .msg_valid(msg_valid), .msg(msg),
    .load_en(load_en), .load_pin(load_pin), .take(take)
  );

  assign msg_dest      = msg.dest;
  assign msg_dest_mode = msg.dest_mode;
  assign msg_deliv     = msg.deliv;
  assign msg_vector    = msg.vector;
  assign msg_polarity  = msg.polarity;
  assign msg_trigger   = msg.trigger;
endmodule

// File: rtl/irt_chk.sv
module irt_chk #(
  parameter int NUM_PINS = 24,
  localparam int PIN_W   = $clog2(NUM_PINS)
) (
  input logic                clk,
  input logic                rst,
  input logic                msg_valid,
  input logic                msg_ready,
  input logic [7:0]          msg_vector,
  input logic [7:0]          msg_dest,
  input logic                bus_rd,
  input logic [7:0]          bus_addr,
  input logic [31:0]         bus_rdata,
  input logic [7:0]          sel_idx,
  input logic                load_en,
  input logic [PIN_W-1:0]    load_pin,
  input logic [NUM_PINS-1:0] mask_vec,
  input logic [NUM_PINS-1:0] pend_vec
);
  localparam logic [31:0] CAP_WORD = 32'h11 | (32'(NUM_PINS - 1) << 16);

  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (rst)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_vector) && $stable(msg_dest)); // R11
  AST_NO_MASKED_SEND: assert property (@(posedge clk) disable iff (rst)
    load_en |-> !mask_vec[load_pin]); // R9
  AST_SEND_NEEDS_PENDING: assert property (@(posedge clk) disable iff (rst)
    load_en |-> pend_vec[load_pin]); // R7
  AST_CAP_READ: assert property (@(posedge clk) disable iff (rst)
    bus_rd && bus_addr == 8'h10 && sel_idx == 8'd1 |=> bus_rdata == CAP_WORD); // R3
  AST_SELECT_READ: assert property (@(posedge clk) disable iff (rst)
    bus_rd && bus_addr == 8'h00 |=> bus_rdata[31:8] == 24'h0); // R1
endmodule

bind irq_route_table irt_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_vector(msg_vector), .msg_dest(msg_dest), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .sel_idx(sel_idx),
  .load_en(load_en), .load_pin(load_pin), .mask_vec(mask_vec),
  .pend_vec(pend_vec)
);

// File: tb/sim_irq_route_table.sv
`timescale 1ns/1ps
module sim_irq_route_table;
  localparam int NP = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NP-1:0] irq_line = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, msg_ready = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic msg_valid, msg_dest_mode, msg_polarity, msg_trigger;
  logic [7:0] msg_dest, msg_vector;
  logic [2:0] msg_deliv;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_route_table #(.NUM_PINS(NP)) u0 (
    .clk(clk), .rst(rst), .irq_line(irq_line), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .msg_ready(msg_ready), .msg_valid(msg_valid), .msg_dest(msg_dest),
    .msg_dest_mode(msg_dest_mode), .msg_deliv(msg_deliv), .msg_vector(msg_vector),
    .msg_polarity(msg_polarity), .msg_trigger(msg_trigger)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic put_entry(input int n, input logic [31:0] hi, input logic [31:0] lo);
    bus_write(8'h00, 32'(8'h11 + 2 * n)); bus_write(8'h10, hi);
    bus_write(8'h00, 32'(8'h10 + 2 * n)); bus_write(8'h10, lo);
  endtask

  task automatic sel_read(input logic [7:0] idx, output logic [31:0] d);
    bus_write(8'h00, {24'h0, idx});
    bus_read(8'h10, d);
  endtask

  task automatic pulse(input logic [NP-1:0] lines);
    irq_line = irq_line | lines;
    @(negedge clk);
    irq_line = irq_line & ~lines;
  endtask

  task automatic wait_valid(input string tag);
    for (int i = 0; i < 10 && !msg_valid; i++) @(negedge clk);
    chk(msg_valid, tag, {31'h0, msg_valid}, 32'h1);
  endtask

  task automatic accept(input string tag, input logic [7:0] vec);
    chk(msg_valid && msg_vector == vec, tag, {23'h0, msg_valid, msg_vector}, {24'h1, vec});
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
  endtask

  task automatic quiet(input string tag, input int cycles);
    bit seen = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (msg_valid) seen = 1'b1;
    end
    chk(!seen, tag, {31'h0, seen}, 32'h0);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk(!msg_valid, "R6 msg_valid after reset", {31'h0, msg_valid}, 32'h0);
    bus_read(8'h00, d);  chk(d == 0, "R6 select after reset", d, 0);
    sel_read(8'h00, d);  chk(d == 0, "R6 id after reset", d, 0);
    sel_read(8'h10, d);  chk(d == 32'h0001_0000, "R6 entry0 low", d, 32'h0001_0000);
    sel_read(8'h3F, d);  chk(d == 0, "R6 entry23 high", d, 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    bus_write(8'h00, 32'hFFFF_FFA5); bus_read(8'h00, d);
    chk(d == 32'hA5, "R1 select readback", d, 32'hA5);
    bus_write(8'h00, 0); bus_write(8'h10, 32'hFFFF_FFFF); bus_read(8'h10, d);
    chk(d == 32'hFF00_0000, "R2 id write", d, 32'hFF00_0000);
    bus_write(8'h00, 1); bus_write(8'h10, 32'h1234_5678); bus_read(8'h10, d);
    chk(d == 32'h0017_0011, "R3 capability word", d, 32'h0017_0011);
    bus_write(8'h00, 2); bus_write(8'h10, 32'hFFFF_FFFF); bus_read(8'h10, d);
    chk(d == 0, "R3 select 2 reads zero", d, 0);
    bus_write(8'h00, 8'h40); bus_write(8'h10, 32'hFFFF_FFFF); bus_read(8'h10, d);
    chk(d == 0, "R3 unused select", d, 0);
    bus_read(8'h20, d);
    chk(d == 0, "R3 unused offset", d, 0);
    put_entry(4, 32'hCAFE_0001, 32'h1234_5678);
    bus_write(8'h00, 8'h19); bus_write(8'h10, 32'h0BAD_F00D);
    sel_read(8'h18, d); chk(d == 32'h1234_5678, "R4 low half kept", d, 32'h1234_5678);
    sel_read(8'h19, d); chk(d == 32'h0BAD_F00D, "R4 high half written", d, 32'h0BAD_F00D);
    bus_write(8'h00, 8'h18); bus_write(8'h10, 32'h0001_0000);
    sel_read(8'h18, d); chk(d == 32'h0001_0000, "R4 low half rewritten", d, 32'h0001_0000);
    sel_read(8'h19, d); chk(d == 32'h0BAD_F00D, "R4 high half kept", d, 32'h0BAD_F00D);
  endtask

  task automatic t_edge;
    // entry 5: vector 0x45, delivery 1, dest mode 1, polarity 1, edge, dest 0x3C
    put_entry(5, 32'h3C00_0000, 32'h0000_2945);
    irq_line[5] = 1'b1;
    @(negedge clk);
    chk(!msg_valid, "R7 not due after one edge", {31'h0, msg_valid}, 0);
    @(negedge clk);
    chk(msg_valid, "R7 due after two edges", {31'h0, msg_valid}, 1);
    chk(msg_dest == 8'h3C && msg_dest_mode && msg_deliv == 3'd1 && msg_polarity && !msg_trigger,
        "R5 message fields", {msg_dest, 4'h0, msg_dest_mode, msg_deliv, 6'h0, msg_polarity, msg_trigger, 8'h0},
        {8'h3C, 4'h0, 1'b1, 3'd1, 6'h0, 1'b1, 1'b0, 8'h0});
    accept("R7 edge message", 8'h45);
    quiet("R7 held line sends once", 6);
    irq_line[5] = 1'b0;
  endtask

  task automatic t_level;
    put_entry(7, 32'h0100_0000, 32'h0000_8077);
    irq_line[7] = 1'b1;
    wait_valid("R8 level message");
    chk(msg_trigger, "R8 trigger flag", {31'h0, msg_trigger}, 1);
    accept("R8 level vector", 8'h77);
    quiet("R8 no resend while high", 6);
    irq_line[7] = 1'b0;
    quiet("R8 no message when low", 3);
    irq_line[7] = 1'b1;
    wait_valid("R8 re-armed after low");
    accept("R8 second message", 8'h77);
    irq_line[7] = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_mask;
    put_entry(9, 32'h0, 32'h0001_0099);
    pulse(NP'(1) << 9);
    quiet("R9 masked entry silent", 6);
    bus_write(8'h00, 8'h22); bus_write(8'h10, 32'h0000_0099);
    wait_valid("R9 unmask sends kept edge");
    accept("R9 unmasked vector", 8'h99);
    quiet("R9 single message", 3);
  endtask

  task automatic t_order;
    put_entry(3, 32'h0, 32'h0000_0033);
    put_entry(11, 32'h0, 32'h0000_00BB);
    pulse((NP'(1) << 11) | (NP'(1) << 3));
    wait_valid("R10 first message");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(msg_valid && msg_vector == 8'h33, "R11 held while stalled",
          {23'h0, msg_valid, msg_vector}, {24'h1, 8'h33});
    end
    accept("R10 lowest entry first", 8'h33);
    chk(msg_valid, "R11 next loaded on transfer edge", {31'h0, msg_valid}, 1);
    accept("R10 then higher entry", 8'hBB);
    quiet("R10 no extra message", 3);
  endtask

  task automatic t_remap;
    put_entry(2, 32'h0, 32'h0000_0022);
    put_entry(0, 32'h0, 32'h0000_0010);
    pulse(NP'(1));
    wait_valid("R12 line 0 raises entry 2");
    accept("R12 entry 2 vector", 8'h22);
    quiet("R12 entry 0 never raised", 5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_edge();
    t_level();
    t_mask();
    t_order();
    t_remap();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule